// File: doc/BRIEF.md
# PWM Channel Compare Action Unit

This block is one output channel of a PWM timer. It watches the count value of a shared up/down counter. In every cycle in which the counter signals a count event, it compares that value with a 16-bit threshold. When the two are equal, it applies a programmable action to a registered output bit. Four copies, each with its own threshold and action, make up the four outputs of one timer.

Some actions have two halves. The first half runs on a threshold match. The second half runs on a second event, and what that event is depends on the counting style. When the counter runs as a sawtooth, the second event is the counter's end-of-range pulse. When the counter runs up and down (center-aligned), the second event is the next match, and a pending flag records which half comes next.

The threshold and the action code live in shadow registers. They change only when the update strobe is pulsed. The strobe is asserted on the timer's first start and on every explicit update command.

Top module: `pwm_cmp_chan`

## Requirements
- R1: While `rst_ni` is low, `pwm_o` is 0 and the pending flag is cleared.
- R2: `thr_i` and `act_i` are copied into the shadow registers only at a clock edge where `load_i` is 1. Changing them without `load_i` has no effect on later matches.
- R3: In a cycle with `tick_i` = 0, `pwm_o` and the pending flag keep their values, whatever `count_i` and `wrap_i` are.
- R4: Action code 0 (set) drives `pwm_o` to 1 at the edge after a match, that is, a cycle with `tick_i` = 1 and `count_i` equal to the shadow threshold. Non-matching ticks hold the output.
- R5: Action code 4 (clear) drives `pwm_o` to 0 at the edge after a match.
- R6: Action code 3 (toggle) inverts `pwm_o` at the edge after each match.
- R7: With `sawtooth_i` = 1, the two-phase codes apply their first half on a match and their second half on a tick with `wrap_i` = 1. The halves are: 1 = toggle, then clear; 2 = set, then clear; 5 = toggle, then set; 6 = clear, then set. In this mode the pending flag is unchanged.
- R8: With `sawtooth_i` = 1, a tick that is both a match and an end of range applies only the first half.
- R9: With `sawtooth_i` = 0, a match with a two-phase code applies the first half and sets the pending flag if the flag was low. If the flag was high, the match applies the second half and clears the flag. `wrap_i` has no effect in this mode.
- R10: Action code 7 leaves `pwm_o` unchanged on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Update strobe: capture threshold and action code |
| thr_i | input | CW | Threshold to capture |
| act_i | input | 3 | Action code to capture |
| sawtooth_i | input | 1 | 1 = sawtooth counting, 0 = center-aligned counting |
| tick_i | input | 1 | Count event from the counter |
| count_i | input | CW | Current count value |
| wrap_i | input | 1 | End-of-range pulse from the counter |
| pwm_o | output | 1 | Channel output bit |

## Verification
Each single-phase code gets ticks whose count matches the threshold and ticks whose count does not. This separates an action that fires on a match from an action that fires on every tick. Every two-phase code runs first in sawtooth mode, with a match followed by an end of range, starting from a known low output. The result shows that each half performs its own operation. Center-aligned runs then send an end-of-range pulse between two matches to show that the pending flag, not the pulse, selects the second half. Further patterns cover a match in the load cycle against a stale input threshold, idle cycles with a matching count, and a match coinciding with an end of range, which checks the half priority.

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] thr_i,
  input  logic [2:0]    act_i,
  input  logic          sawtooth_i,
  input  logic          tick_i,
  input  logic [CW-1:0] count_i,
  input  logic          wrap_i,
  output logic          pwm_o
);

  localparam logic [1:0] OP_HOLD = 2'd0;
  localparam logic [1:0] OP_SET  = 2'd1;
  localparam logic [1:0] OP_CLR  = 2'd2;
  localparam logic [1:0] OP_TOG  = 2'd3;

  logic [CW-1:0] thr_q;
  logic [2:0]    act_q;
  logic          pend_q, pend_d;
  logic          pwm_q, pwm_d;
  logic [1:0]    op_first, op_second, op_sel;

  wire hit  = tick_i && (count_i == thr_q);
  wire wrap = tick_i && wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
      act_q <= 3'd7;
    end else if (load_i) begin
      thr_q <= thr_i;
      act_q <= act_i;
    end
  end

  always_comb begin
    op_first  = OP_HOLD;
    op_second = OP_HOLD;
    case (act_q)
      3'd0: op_first = OP_SET;
      3'd1: begin op_first = OP_TOG; op_second = OP_CLR; end
      3'd2: begin op_first = OP_SET; op_second = OP_CLR; end
      3'd3: op_first = OP_TOG;
      3'd4: op_first = OP_CLR;
      3'd5: begin op_first = OP_TOG; op_second = OP_SET; end
      3'd6: begin op_first = OP_CLR; op_second = OP_SET; end
      default: ;
    endcase
  end

  always_comb begin
    op_sel = OP_HOLD;
    pend_d = pend_q;
    if (op_second == OP_HOLD) begin
      if (hit) op_sel = op_first;
    end else if (sawtooth_i) begin
      if (hit)       op_sel = op_first;
      else if (wrap) op_sel = op_second;
    end else if (hit) begin
      op_sel = pend_q ? op_second : op_first;
      pend_d = !pend_q;
    end
  end

  always_comb begin
    case (op_sel)
      OP_SET:  pwm_d = 1'b1;
      OP_CLR:  pwm_d = 1'b0;
      OP_TOG:  pwm_d = !pwm_q;
      default: pwm_d = pwm_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pwm_q  <= pwm_d;
      pend_q <= pend_d;
    end
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [CW-1:0] thr_i,
  input logic [2:0]    act_i,
  input logic          sawtooth_i,
  input logic          tick_i,
  input logic [CW-1:0] count_i,
  input logic          pwm_o,
  input logic [CW-1:0] thr_q,
  input logic [2:0]    act_q,
  input logic          pend_q
);

  wire match = tick_i && (count_i == thr_q);
  wire two_phase = (act_q == 3'd1) || (act_q == 3'd2) || (act_q == 3'd5) || (act_q == 3'd6);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (thr_q == $past(thr_i)) && (act_q == $past(act_i)));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pwm_o) && $stable(pend_q));

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && act_q == 3'd0) |=> pwm_o);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && act_q == 3'd4) |=> !pwm_o);

  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && act_q == 3'd3) |=> (pwm_o != $past(pwm_o)));

  p_saw_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sawtooth_i |=> $stable(pend_q));

  p_center_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sawtooth_i && match && two_phase) |=> (pend_q != $past(pend_q)));

  p_spare_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == 3'd7) |=> $stable(pwm_o));

endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .thr_i(thr_i),
  .act_i(act_i), .sawtooth_i(sawtooth_i), .tick_i(tick_i),
  .count_i(count_i), .pwm_o(pwm_o), .thr_q(thr_q), .act_q(act_q),
  .pend_q(pend_q)
);

// File: tb/pwm_cmp_chan_tb.sv
module pwm_cmp_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [CW-1:0] thr_i = '0;
  logic [2:0]    act_i = '0;
  logic          sawtooth_i = 1'b0;
  logic          tick_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          wrap_i = 1'b0;
  logic          pwm_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_cmp_chan #(.CW(CW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .thr_i(thr_i),
    .act_i(act_i), .sawtooth_i(sawtooth_i), .tick_i(tick_i),
    .count_i(count_i), .wrap_i(wrap_i), .pwm_o(pwm_o)
  );

  task automatic chk(input logic exp, input string tag);
    n_vec++;
    if (pwm_o !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm_o=%b expected %b", tag, pwm_o, exp);
    end
  endtask

  task automatic setup(input int thr, input int act);
    thr_i = CW'(thr); act_i = 3'(act); load_i = 1'b1; tick_i = 1'b0; wrap_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic step(input logic tk, input int cnt, input logic wr);
    tick_i = tk; count_i = CW'(cnt); wrap_i = wr;
    @(negedge clk_i);
    tick_i = 1'b0; wrap_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(1'b0, "R1 output low in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1'b0, "R1 output low after reset");
  endtask

  task automatic t_set;
    setup(5, 0);
    step(1, 3, 0); chk(1'b0, "R4 set ignores non-match");
    step(1, 5, 0); chk(1'b1, "R4 set on match");
    step(1, 6, 0); chk(1'b1, "R4 set holds");
  endtask

  task automatic t_idle_clear;
    setup(5, 4);
    step(0, 5, 1); chk(1'b1, "R3 no tick holds output");
    step(1, 5, 0); chk(1'b0, "R5 clear on match");
    step(1, 2, 0); chk(1'b0, "R5 clear holds");
  endtask

  task automatic t_toggle;
    setup(7, 3);
    step(1, 7, 0); chk(1'b1, "R6 toggle first match");
    step(1, 2, 0); chk(1'b1, "R6 toggle non-match holds");
    step(1, 7, 0); chk(1'b0, "R6 toggle second match");
  endtask

  task automatic t_shadow;
    thr_i = CW'(9); act_i = 3'd0;
    step(1, 9, 0); chk(1'b0, "R2 unloaded threshold ignored");
    step(1, 7, 0); chk(1'b1, "R2 old threshold and action kept");
  endtask

  task automatic t_spare;
    setup(4, 7);
    step(1, 4, 0); chk(1'b1, "R10 code 7 holds on match");
    step(1, 4, 1); chk(1'b1, "R10 code 7 holds on end of range");
  endtask

  task automatic t_sawtooth;
    int modes [4] = '{1, 2, 5, 6};
    logic e1 [4] = '{1'b1, 1'b1, 1'b1, 1'b0};
    logic e2 [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
    sawtooth_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      setup(3, 4); step(1, 3, 0);
      chk(1'b0, "R7 preset low");
      setup(3, modes[i]);
      step(1, 3, 0); chk(e1[i], $sformatf("R7 code %0d first half", modes[i]));
      step(1, 8, 0); chk(e1[i], $sformatf("R7 code %0d holds between", modes[i]));
      step(1, 8, 1); chk(e2[i], $sformatf("R7 code %0d second half on end", modes[i]));
    end
    setup(3, 4); step(1, 3, 0);
    setup(3, 1);
    step(1, 3, 1); chk(1'b1, "R8 match wins over end of range");
    step(1, 9, 1); chk(1'b0, "R8 end of range alone clears");
  endtask

  task automatic t_center;
    sawtooth_i = 1'b0;
    setup(3, 4); step(1, 3, 0); chk(1'b0, "R9 preset low");
    setup(3, 2);
    step(1, 3, 0); chk(1'b1, "R9 code 2 first match sets");
    step(1, 9, 1); chk(1'b1, "R9 end of range ignored");
    step(1, 3, 0); chk(1'b0, "R9 code 2 second match clears");
    step(1, 3, 0); chk(1'b1, "R9 code 2 third match sets again");
    step(1, 3, 0); chk(1'b0, "R9 code 2 fourth match clears");
    setup(3, 6);
    step(1, 3, 0); chk(1'b0, "R9 code 6 first match clears");
    step(1, 3, 0); chk(1'b1, "R9 code 6 second match sets");
    setup(3, 5);
    step(1, 3, 0); chk(1'b0, "R9 code 5 first match toggles");
    step(1, 3, 0); chk(1'b1, "R9 code 5 second match sets");
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_set();
    t_idle_clear();
    t_toggle();
    t_shadow();
    t_spare();
    t_sawtooth();
    t_center();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule